// File: doc/BRIEF.md
# Addressed Serial Bus Word Receiver

This block watches a clocked serial control bus shared by several units. A strobe marks the start of each word. Data bits arrive on the rising edges of the bus clock. Both bus lines are sampled in the system clock domain and edge-detected there. A frame counter restarts from zero on each strobe and counts bus clock edges. The count, together with a host-controlled enable, indexes a computed timing table. The table yields four single-cycle control pulses: word clear, status check, payload load and transmit end.

Each word is 15 bits long and is sent MSB first, in this order:
- one leading bit;
- a 5-bit destination address;
- a direction bit;
- an 8-bit payload.

At the status check, the address field is compared with the unit address supplied by the host. When the address matches, the direction bit selects the action. A direction bit of 0 means receive: the payload is latched into a one-byte buffer at the load pulse, and an interrupt is raised for the host. A direction bit of 1 means transmit: a transmit-enable output is held high for the payload slots, so an external shifter can drive them. The host reads the buffered byte on a parallel port, and a read strobe acknowledges the interrupt.

Top module: `sbus_word_rx`

## Requirements
- R1: A rising edge on `bus_strobe_i` resets the frame count to zero, so the next bus clock edge carries the leading bit of a new word, whatever bits came before the strobe.
- R2: Each rising edge of `bus_clk_i` shifts in `bus_data_i` and advances the count by one. The count saturates at 127, and bits past the end of a word cause no action.
- R3: While `addr_en_i` is low, no timing pulse is produced, so words are ignored completely: buffer, interrupt and transmit enable keep their values.
- R4: Word bits are numbered 0 to 14 in arrival order. Bit 0 is the leading bit and its value is ignored. Bits 1 to 5 are the address, MSB first. Bit 6 is the direction bit (0 = receive, 1 = transmit). Bits 7 to 14 are the payload, MSB first.
- R5: The status check happens after bit 6 has arrived. A word whose address differs from `unit_addr_i` causes no buffer write, no interrupt and no transmit enable.
- R6: For a matching word with direction 1, `xmit_en_o` rises two system clocks after the bus clock edge of bit 6. It falls two system clocks after the bus clock edge of bit 14.
- R7: For a matching word with direction 0, the payload is in `rd_data_o` two system clocks after the bus clock edge of bit 14. Apart from this, the buffer never changes.
- R8: `rx_irq_o` rises in the same cycle that the payload is loaded. A new load keeps it high. A one-cycle pulse on `rd_i` clears it at the next clock edge.
- R9: After reset, `rd_data_o` is 0, `rx_irq_o` is low and `xmit_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_strobe_i | input | 1 | Bus word strobe, rising edge starts a word |
| bus_clk_i | input | 1 | Bus bit clock, sampled by `clk_i` |
| bus_data_i | input | 1 | Bus serial data |
| addr_en_i | input | 1 | Host enable for the timing decode |
| unit_addr_i | input | 5 | Address of this unit |
| rd_i | input | 1 | Host read strobe, acknowledges the interrupt |
| rd_data_o | output | 8 | Buffered received byte |
| rx_irq_o | output | 1 | Byte-received interrupt |
| xmit_en_o | output | 1 | Transmit enable for the payload slots |

## Verification
A wrong frame count or a misaligned shift register becomes visible at the ports only at the status or load point of the next word. It shows either as a wrong byte on `rd_data_o` or as a missing or spurious edge on `rx_irq_o` or `xmit_en_o`, at most 15 bus clock edges later. A stuck address comparison or direction decode shows at the end of the first word sent to this unit. Every output is compared with the model on every clock, so a wrong value is caught in the cycle it first appears.

// File: rtl/sbus_rx_pkg.sv
package sbus_rx_pkg;
  localparam int CNT_W    = 7;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int NCTL     = 4;
  localparam int CLR_CNT  = 1;
  localparam int STAT_CNT = ADDR_W + 2;
  localparam int LOAD_CNT = STAT_CNT + DATA_W;

  typedef enum int {CTL_CLR = 0, CTL_STAT = 1, CTL_LOAD = 2, CTL_TXEND = 3} ctl_e;

  // timing table entry: index = {enable, count}
  function automatic logic [NCTL-1:0] tdec(input int idx, input int cnt_w);
    logic [NCTL-1:0] v;
    int c;
    v = '0;
    c = idx % (1 << cnt_w);
    if ((idx >> cnt_w) % 2 == 1) begin
      v[CTL_CLR]   = (c == CLR_CNT);
      v[CTL_STAT]  = (c == STAT_CNT);
      v[CTL_LOAD]  = (c == LOAD_CNT);
      v[CTL_TXEND] = (c == LOAD_CNT);
    end
    return v;
  endfunction
endpackage

// File: rtl/sbus_frame_ctr.sv
module sbus_frame_ctr #(
  parameter int CNT_W = sbus_rx_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             bclk_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             shift_o,
  output logic             fresh_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic stb_q, bclk_q, fresh_q;
  logic [CNT_W-1:0] cnt_q;
  logic stb_edge, tick;

  assign stb_edge = strobe_i & ~stb_q;
  assign tick     = bclk_i & ~bclk_q;
  assign shift_o  = tick & ~stb_edge;
  assign cnt_o    = cnt_q;
  assign fresh_o  = fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q   <= 1'b0;
      bclk_q  <= 1'b0;
      fresh_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      stb_q   <= strobe_i;
      bclk_q  <= bclk_i;
      fresh_q <= shift_o;
      if (stb_edge)                      cnt_q <= '0;
      else if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !stb_q) |=> cnt_o == '0); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1); // R2
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !(strobe_i && !stb_q)) |=> cnt_o == CNT_MAX); // R2
endmodule

// File: rtl/sbus_timing_dec.sv
module sbus_timing_dec #(
  parameter int CNT_W = sbus_rx_pkg::CNT_W,
  parameter int NCTL  = sbus_rx_pkg::NCTL
) (
  input  logic             addr_en_i,
  input  logic             fresh_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [NCTL-1:0]  ctl_o
);
  localparam int DEPTH = 1 << (CNT_W + 1);

  logic [NCTL-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = sbus_rx_pkg::tdec(i, CNT_W);
  end

  assign ctl_o = fresh_i ? rom[{addr_en_i, cnt_i}] : '0;

  always_comb begin
    AST_CTL_GATED: assert (addr_en_i || ctl_o == '0); // R3
  end
endmodule

// File: rtl/sbus_word_dec.sv
module sbus_word_dec
  import sbus_rx_pkg::*;
#(
  parameter int ADDR_W = sbus_rx_pkg::ADDR_W,
  parameter int DATA_W = sbus_rx_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              data_i,
  input  logic [NCTL-1:0]   ctl_i,
  input  logic [ADDR_W-1:0] unit_addr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              irq_o,
  output logic              xmit_o
);
  localparam int SR_W = (ADDR_W + 2 > DATA_W) ? ADDR_W + 2 : DATA_W;

  logic [SR_W-1:0]   sr_q;
  logic [DATA_W-1:0] buf_q;
  logic              rcv_q, xmit_q, irq_q;
  logic              match, dir;
  logic              p_clr, p_stat, p_load, p_txend;

  assign p_clr   = ctl_i[CTL_CLR];
  assign p_stat  = ctl_i[CTL_STAT];
  assign p_load  = ctl_i[CTL_LOAD];
  assign p_txend = ctl_i[CTL_TXEND];
  // at the status point: sr[ADDR_W:1] = address, sr[0] = direction
  assign match   = (sr_q[ADDR_W:1] == unit_addr_i);
  assign dir     = sr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      buf_q  <= '0;
      rcv_q  <= 1'b0;
      xmit_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (shift_i) sr_q <= {sr_q[SR_W-2:0], data_i};
      if (p_clr) begin
        rcv_q  <= 1'b0;
        xmit_q <= 1'b0;
      end
      if (p_stat) begin
        rcv_q  <= match & ~dir;
        xmit_q <= match & dir;
      end
      if (p_load) begin
        if (rcv_q) buf_q <= sr_q[DATA_W-1:0];
        rcv_q <= 1'b0;
      end
      if (p_txend) xmit_q <= 1'b0;
      if (p_load && rcv_q) irq_q <= 1'b1;
      else if (rd_i)       irq_q <= 1'b0;
    end
  end

  assign buf_o  = buf_q;
  assign irq_o  = irq_q;
  assign xmit_o = xmit_q;

  AST_XMIT_FROM_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xmit_o) |-> $past(ctl_i[CTL_STAT])); // R6
  AST_NO_MATCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i[CTL_STAT] && sr_q[ADDR_W:1] != unit_addr_i) |=> !xmit_o); // R5
  AST_IRQ_FROM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ctl_i[CTL_LOAD])); // R8
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !ctl_i[CTL_LOAD]) |=> !irq_o); // R8
  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i[CTL_LOAD] |=> $stable(buf_o)); // R7
endmodule

// File: rtl/sbus_word_rx.sv
module sbus_word_rx
  import sbus_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_strobe_i,
  input  logic              bus_clk_i,
  input  logic              bus_data_i,
  input  logic              addr_en_i,
  input  logic [ADDR_W-1:0] unit_addr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_irq_o,
  output logic              xmit_en_o
);
  logic [CNT_W-1:0] cnt;
  logic             shift, fresh;
  logic [NCTL-1:0]  ctl;

  sbus_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (bus_strobe_i),
    .bclk_i   (bus_clk_i),
    .cnt_o    (cnt),
    .shift_o  (shift),
    .fresh_o  (fresh)
  );

  sbus_timing_dec #(.CNT_W(CNT_W), .NCTL(NCTL)) u_dec (
    .addr_en_i (addr_en_i),
    .fresh_i   (fresh),
    .cnt_i     (cnt),
    .ctl_o     (ctl)
  );

  sbus_word_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_word (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (shift),
    .data_i      (bus_data_i),
    .ctl_i       (ctl),
    .unit_addr_i (unit_addr_i),
    .rd_i        (rd_i),
    .buf_o       (rd_data_o),
    .irq_o       (rx_irq_o),
    .xmit_o      (xmit_en_o)
  );
endmodule

// File: tb/sbus_word_rx_tb_top.sv
module sbus_word_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0, bclk = 1'b0, bdata = 1'b0, aen = 1'b1, rd = 1'b0;
  logic [4:0] uaddr = 5'h16;
  logic [7:0] rd_data;
  logic       irq, xmit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit run_cmp = 0;

  // reference model state
  bit         hist[$];
  int         ref_cnt = 0;
  bit         ref_rcv = 0;
  logic [7:0] exp_data = '0;
  bit         exp_irq = 0, exp_xmit = 0;

  always #2 clk = ~clk;

  sbus_word_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_strobe_i(strobe), .bus_clk_i(bclk),
    .bus_data_i(bdata), .addr_en_i(aen), .unit_addr_i(uaddr), .rd_i(rd),
    .rd_data_o(rd_data), .rx_irq_o(irq), .xmit_en_o(xmit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) if (run_cmp) begin
    chk("R8 irq", int'(irq), int'(exp_irq));
    chk("R6 xmit", int'(xmit), int'(exp_xmit));
    chk("R7 data", int'(rd_data), int'(exp_data));
  end

  task automatic model_bit();
    logic [4:0] a;
    logic [7:0] p;
    if (ref_cnt < 127) ref_cnt++;
    if (!aen) return;
    if (ref_cnt == 1) begin
      ref_rcv = 0; exp_xmit = 0;
    end
    if (ref_cnt == 7) begin
      for (int i = 1; i <= 5; i++) a[5-i] = hist[i];
      ref_rcv  = (a == uaddr) && !hist[6];
      exp_xmit = (a == uaddr) && hist[6];
    end
    if (ref_cnt == 15) begin
      for (int i = 7; i <= 14; i++) p[14-i] = hist[i];
      if (ref_rcv) begin
        exp_data = p; exp_irq = 1;
      end
      ref_rcv = 0; exp_xmit = 0;
    end
  endtask

  task automatic bus_bit(input bit b);
    bdata = b; bclk = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    hist.push_back(b);
    model_bit();
    @(negedge clk); bclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_strobe();
    strobe = 1'b1;
    @(posedge clk); #1;
    ref_cnt = 0; hist.delete();
    @(negedge clk); strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_word(input bit lead, input logic [4:0] a, input bit d, input logic [7:0] p);
    bus_strobe();
    bus_bit(lead);
    for (int i = 4; i >= 0; i--) bus_bit(a[i]);
    bus_bit(d);
    for (int i = 7; i >= 0; i--) bus_bit(p[i]);
  endtask

  task automatic host_read();
    rd = 1'b1;
    @(posedge clk); #1;
    exp_irq = 0;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset data", int'(rd_data), 0);
    chk("R9 reset irq", int'(irq), 0);
    chk("R9 reset xmit", int'(xmit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmp = 1;

    // R4 R7 R8: matching receive word
    send_word(1'b1, 5'h16, 1'b0, 8'hA5);
    repeat (2) @(negedge clk);
    chk("R7 payload A5", int'(rd_data), 'hA5);
    chk("R8 irq set", int'(irq), 1);
    host_read();
    chk("R8 irq cleared by read", int'(irq), 0);
    chk("R7 data kept after read", int'(rd_data), 'hA5);

    // R5: address mismatch ignored
    send_word(1'b0, 5'h17, 1'b0, 8'h3C);
    send_word(1'b0, 5'h06, 1'b1, 8'hFF);
    repeat (2) @(negedge clk);
    chk("R5 mismatch no irq", int'(irq), 0);
    chk("R5 mismatch no xmit", int'(xmit), 0);
    chk("R5 mismatch buffer held", int'(rd_data), 'hA5);

    // R6: transmit request window
    bus_strobe();
    bus_bit(1'b1);
    for (int i = 4; i >= 0; i--) bus_bit(uaddr[i]);
    chk("R6 xmit low before dir", int'(xmit), 0);
    bus_bit(1'b1);
    chk("R6 xmit raised", int'(xmit), 1);
    for (int i = 0; i < 7; i++) bus_bit(1'b0);
    chk("R6 xmit held", int'(xmit), 1);
    bus_bit(1'b0);
    chk("R6 xmit dropped", int'(xmit), 0);
    chk("R7 transmit leaves buffer", int'(rd_data), 'hA5);
    chk("R8 transmit no irq", int'(irq), 0);

    // R3: decode disabled
    aen = 1'b0;
    send_word(1'b1, 5'h16, 1'b0, 8'h11);
    send_word(1'b1, 5'h16, 1'b1, 8'h22);
    chk("R3 disabled no irq", int'(irq), 0);
    chk("R3 disabled no xmit", int'(xmit), 0);
    chk("R3 disabled buffer held", int'(rd_data), 'hA5);
    aen = 1'b1;

    // R1: junk bits then strobe realigns
    for (int i = 0; i < 4; i++) bus_bit(1'b1);
    send_word(1'b0, 5'h16, 1'b0, 8'h3C);
    chk("R1 realigned payload", int'(rd_data), 'h3C);
    chk("R1 realigned irq", int'(irq), 1);

    // R8: second load while irq pending, R4 MSB first
    send_word(1'b1, 5'h16, 1'b0, 8'h01);
    chk("R4 payload 01", int'(rd_data), 'h01);
    chk("R8 irq stays set", int'(irq), 1);
    host_read();
    send_word(1'b1, 5'h16, 1'b0, 8'h80);
    chk("R4 payload 80", int'(rd_data), 'h80);
    host_read();

    // R2: trailing bits beyond word, count saturates
    for (int i = 0; i < 140; i++) bus_bit(i[0]);
    chk("R2 trailing no irq", int'(irq), 0);
    chk("R2 trailing no xmit", int'(xmit), 0);
    chk("R2 trailing buffer held", int'(rd_data), 'h80);

    // a fresh word still works after saturation
    uaddr = 5'h09;
    send_word(1'b0, 5'h09, 1'b0, 8'hC3);
    chk("R5 new unit address payload", int'(rd_data), 'hC3);
    chk("R8 new unit address irq", int'(irq), 1);

    repeat (4) @(negedge clk);
    done = 1;
    report();
  end
endmodule